// File: doc/BRIEF.md
# Three-Wire Serial Control Register Bank

This block is a write-only serial slave for a tuner control chip. A host drives three lines: an enable that frames each command, a serial clock, and a data line. While enable is high, the block takes one data bit on each rising serial clock edge. When enable drops, the block looks at how many bits arrived and at the two address bits that came first. It then copies the payload into exactly one internal register, or throws the frame away.

Commands are either two bytes or three bytes long. Within each byte the least significant bit goes first, and byte 1 is sent first. So the k-th bit after enable rises becomes bit k of the command word. The long commands load the reference divider and the feedback divider, each together with its companion control fields. The short commands load the gain and offset of either of two alignment converters, or the crystal tuning capacitor code. The contents of every register are held on parallel output ports. For the capacitor code the block also gives the total capacitance in half-picofarad units.

The serial lines are treated as asynchronous. They are synchronized to the system clock, which runs well above the serial rate, and their edges are detected from the synchronized samples.

Top module: `ctl3w_top`

## Requirements
- R1: While `rst_ni` is low, and after reset, every output is zero. That means the reference and feedback dividers read 0, all four switches are on (0 = on), the buffer is on (0 = on), the mode bit is 0 (tracking mode), and all gain, offset and tuning fields are 0.
- R2: Bits are sampled on rising edges of `ser_clk_i` while `ser_en_i` is high. The k-th sampled bit (k counted from 0) becomes bit k of the command word. Bits [1:0] of that word are the address.
- R3: A 24-bit frame with address 0 loads all four fields of its register together. The fields are: reference divider = word[17:2], converter-3 level = word[20:18], buffer off = word[21], charge-pump code = word[23:22].
- R4: A 24-bit frame with address 1 loads all three fields of its register together. The fields are: feedback divider = word[17:2], switch-off bits = word[21:18] (switch 1 at bit 18), mode bit = word[22]. Bit 23 is ignored.
- R5: A 16-bit frame with address 0 loads converter A. A 16-bit frame with address 1 loads converter B. In both cases gain = word[9:2] and offset = word[15:10].
- R6: A 16-bit frame with address 2 loads the 8-bit capacitor code from word[15:8]. Bits [7:2] of that frame have no effect.
- R7: `tune_half_pf_o` equals the lower seven code bits, plus 16 when the top code bit is set. The result ranges from 0 to 143 half-picofarads.
- R8: A frame whose bit count is neither 16 nor 24 changes no output.
- R9: A 16-bit frame with address 3, or a 24-bit frame with address 2 or 3, changes no output.
- R10: No output changes while a frame is still open. The addressed register updates in a single system-clock cycle after enable falls.
- R11: Serial clock edges while enable is low are ignored. Each frame starts again at bit 0.
- R12: A valid frame leaves every register other than its target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_en_i | input | 1 | Frame enable, high during a command |
| ser_clk_i | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat_i | input | 1 | Serial data |
| ref_div_o | output | 16 | Reference divider value |
| pump_sel_o | output | 2 | Charge-pump current code |
| buf_off_o | output | 1 | Oscillator buffer disable (1 = off) |
| lvl3_o | output | 3 | Converter-3 level code |
| fb_div_o | output | 16 | Feedback divider value |
| sw_off_o | output | 4 | Switch-output disable bits (1 = off, 0 = pulled low) |
| dac_plain_o | output | 1 | Converter mode (0 = tracking, 1 = plain) |
| gain_a_o | output | 8 | Converter A gain |
| ofs_a_o | output | 6 | Converter A offset |
| gain_b_o | output | 8 | Converter B gain |
| ofs_b_o | output | 6 | Converter B offset |
| tune_code_o | output | 8 | Crystal capacitor code |
| tune_half_pf_o | output | 9 | Capacitor total in 0.5 pF units |

## Verification
The bench builds the block with its default parameters: two synchronizer stages and a 16-unit weight for the top capacitor bit. With these values the extreme capacitance codes, 0 and 143, can be reached. Each serial half period lasts 52 system clocks, which keeps the bench inside the bus's minimum high and low times. The frame lengths tried are 8, 15, 16, 17, 23, 24 and 25 bits, so the length decoder is tested on both sides of each accepted value. A frame held open after its last bit shows that the registers do not update until enable falls.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int ADDR_W    = 2;
  localparam int SHORT_LEN = 16;
  localparam int LONG_LEN  = 24;
  localparam int CNT_W     = $clog2(LONG_LEN + 2);

  localparam int DIV_W  = 16;
  localparam int PUMP_W = 2;
  localparam int LVL_W  = 3;
  localparam int SW_N   = 4;
  localparam int DAC_N  = 2;
  localparam int GAIN_W = 8;
  localparam int OFS_W  = 6;
  localparam int TUNE_W = 8;
  localparam int HPF_W  = TUNE_W + 1;

  // long-frame field positions
  localparam int DIV_LSB  = ADDR_W;
  localparam int LVL_LSB  = DIV_LSB + DIV_W;
  localparam int BUF_BIT  = LVL_LSB + LVL_W;
  localparam int PUMP_LSB = BUF_BIT + 1;
  localparam int SW_LSB   = DIV_LSB + DIV_W;
  localparam int MODE_BIT = SW_LSB + SW_N;

  // short-frame field positions
  localparam int GAIN_LSB = ADDR_W;
  localparam int OFS_LSB  = GAIN_LSB + GAIN_W;
  localparam int TUNE_LSB = SHORT_LEN - TUNE_W;

  localparam logic [ADDR_W-1:0] ADR_REF  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_FB   = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_DACA = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_DACB = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_TUNE = 2'd2;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_REF,
    TGT_FB,
    TGT_DACA,
    TGT_DACB,
    TGT_TUNE
  } tgt_e;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= '0;
        else         q_q <= d_i;
      end
      assign q_o = q_q;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
      assign q_o = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift
  import ctl3w_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                sclk_i,
  input  logic                dat_i,
  output logic                done_o,
  output logic [CNT_W-1:0]    len_o,
  output logic [LONG_LEN-1:0] word_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                en_q, sclk_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [LONG_LEN-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      word_q <= '0;
    end else begin
      en_q   <= en_i;
      sclk_q <= sclk_i;
      if (en_i && !en_q) begin
        cnt_q  <= '0;
        word_q <= '0;
      end else if (en_i && sclk_i && !sclk_q) begin
        for (int i = 0; i < LONG_LEN; i++)
          if (cnt_q == CNT_W'(i)) word_q[i] <= dat_i;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;  // saturate: over-long frames stay invalid
      end
    end
  end

  assign done_o = en_q & ~en_i;
  assign len_o  = cnt_q;
  assign word_o = word_q;
endmodule

// File: rtl/ctl3w_decode.sv
module ctl3w_decode
  import ctl3w_pkg::*;
(
  input  logic [CNT_W-1:0]    len_i,
  input  logic [LONG_LEN-1:0] word_i,
  output tgt_e                tgt_o
);
  logic [ADDR_W-1:0] adr;
  assign adr = word_i[ADDR_W-1:0];

  always_comb begin
    tgt_o = TGT_NONE;
    if (len_i == CNT_W'(LONG_LEN)) begin
      if      (adr == ADR_REF) tgt_o = TGT_REF;
      else if (adr == ADR_FB)  tgt_o = TGT_FB;
    end else if (len_i == CNT_W'(SHORT_LEN)) begin
      if      (adr == ADR_DACA) tgt_o = TGT_DACA;
      else if (adr == ADR_DACB) tgt_o = TGT_DACB;
      else if (adr == ADR_TUNE) tgt_o = TGT_TUNE;
    end
  end
endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
  import ctl3w_pkg::*;
#(
  parameter int TUNE_MSB_HALF_PF = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  tgt_e                           tgt_i,
  input  logic [LONG_LEN-1:0]            word_i,
  output logic [DIV_W-1:0]               ref_div_o,
  output logic [PUMP_W-1:0]              pump_o,
  output logic                           buf_off_o,
  output logic [LVL_W-1:0]               lvl_o,
  output logic [DIV_W-1:0]               fb_div_o,
  output logic [SW_N-1:0]                sw_off_o,
  output logic                           mode_o,
  output logic [DAC_N-1:0][GAIN_W-1:0]   gain_o,
  output logic [DAC_N-1:0][OFS_W-1:0]    ofs_o,
  output logic [TUNE_W-1:0]              tune_o,
  output logic [HPF_W-1:0]               half_pf_o
);
  localparam logic [HPF_W-1:0] MSB_STEP = HPF_W'(TUNE_MSB_HALF_PF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_div_o <= '0;
      pump_o    <= '0;
      buf_off_o <= 1'b0;
      lvl_o     <= '0;
    end else if (wr_i && tgt_i == TGT_REF) begin
      ref_div_o <= word_i[DIV_LSB +: DIV_W];
      lvl_o     <= word_i[LVL_LSB +: LVL_W];
      buf_off_o <= word_i[BUF_BIT];
      pump_o    <= word_i[PUMP_LSB +: PUMP_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_div_o <= '0;
      sw_off_o <= '0;
      mode_o   <= 1'b0;
    end else if (wr_i && tgt_i == TGT_FB) begin
      fb_div_o <= word_i[DIV_LSB +: DIV_W];
      sw_off_o <= word_i[SW_LSB +: SW_N];
      mode_o   <= word_i[MODE_BIT];
    end
  end

  generate
    for (genvar ch = 0; ch < DAC_N; ch++) begin : g_dac
      localparam tgt_e CH_TGT = (ch == 0) ? TGT_DACA : TGT_DACB;
      logic [GAIN_W-1:0] gain_q;
      logic [OFS_W-1:0]  ofs_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          gain_q <= '0;
          ofs_q  <= '0;
        end else if (wr_i && tgt_i == CH_TGT) begin
          gain_q <= word_i[GAIN_LSB +: GAIN_W];
          ofs_q  <= word_i[OFS_LSB +: OFS_W];
        end
      end
      assign gain_o[ch] = gain_q;
      assign ofs_o[ch]  = ofs_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tune_o <= '0;
    else if (wr_i && tgt_i == TGT_TUNE)   tune_o <= word_i[TUNE_LSB +: TUNE_W];
  end

  assign half_pf_o = (tune_o[TUNE_W-1] ? MSB_STEP : '0) + HPF_W'(tune_o[TUNE_W-2:0]);
endmodule

// File: rtl/ctl3w_top.sv
module ctl3w_top
  import ctl3w_pkg::*;
#(
  parameter int SYNC_STAGES      = 2,
  parameter int TUNE_MSB_HALF_PF = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_en_i,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  output logic [DIV_W-1:0]  ref_div_o,
  output logic [PUMP_W-1:0] pump_sel_o,
  output logic              buf_off_o,
  output logic [LVL_W-1:0]  lvl3_o,
  output logic [DIV_W-1:0]  fb_div_o,
  output logic [SW_N-1:0]   sw_off_o,
  output logic              dac_plain_o,
  output logic [GAIN_W-1:0] gain_a_o,
  output logic [OFS_W-1:0]  ofs_a_o,
  output logic [GAIN_W-1:0] gain_b_o,
  output logic [OFS_W-1:0]  ofs_b_o,
  output logic [TUNE_W-1:0] tune_code_o,
  output logic [HPF_W-1:0]  tune_half_pf_o
);
  logic [2:0]                 ser_s;
  logic                       frame_done;
  logic [CNT_W-1:0]           frame_len;
  logic [LONG_LEN-1:0]        frame_word;
  tgt_e                       frame_tgt;
  logic [DAC_N-1:0][GAIN_W-1:0] gain;
  logic [DAC_N-1:0][OFS_W-1:0]  ofs;

  // all three lines share one chain so their relative timing is preserved
  ctl3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ser_en_i, ser_clk_i, ser_dat_i}),
    .q_o    (ser_s)
  );

  ctl3w_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ser_s[2]),
    .sclk_i (ser_s[1]),
    .dat_i  (ser_s[0]),
    .done_o (frame_done),
    .len_o  (frame_len),
    .word_o (frame_word)
  );

  ctl3w_decode u_decode (
    .len_i  (frame_len),
    .word_i (frame_word),
    .tgt_o  (frame_tgt)
  );

  ctl3w_regs #(.TUNE_MSB_HALF_PF(TUNE_MSB_HALF_PF)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (frame_done),
    .tgt_i     (frame_tgt),
    .word_i    (frame_word),
    .ref_div_o (ref_div_o),
    .pump_o    (pump_sel_o),
    .buf_off_o (buf_off_o),
    .lvl_o     (lvl3_o),
    .fb_div_o  (fb_div_o),
    .sw_off_o  (sw_off_o),
    .mode_o    (dac_plain_o),
    .gain_o    (gain),
    .ofs_o     (ofs),
    .tune_o    (tune_code_o),
    .half_pf_o (tune_half_pf_o)
  );

  assign gain_a_o = gain[0];
  assign ofs_a_o  = ofs[0];
  assign gain_b_o = gain[1];
  assign ofs_b_o  = ofs[1];
endmodule

// File: rtl/ctl3w_chk.sv
module ctl3w_chk
  import ctl3w_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                done_i,
  input logic [CNT_W-1:0]    len_i,
  input logic [LONG_LEN-1:0] word_i,
  input logic [DIV_W-1:0]    ref_div_i,
  input logic [87:0]         state_i
);
  logic len_ok, is_short;
  assign is_short = (len_i == CNT_W'(SHORT_LEN));
  assign len_ok   = is_short || (len_i == CNT_W'(LONG_LEN));

  always @(posedge clk_i)
    if (!rst_ni) assert_reset_zero_R1: assert (state_i == '0);

  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(state_i));

  assert_bad_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !len_ok) |=> $stable(state_i));

  assert_bad_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && is_short && word_i[1:0] == 2'd3) |=> $stable(state_i));

  assert_ref_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && len_i == CNT_W'(LONG_LEN) && word_i[1:0] == ADR_REF)
      |=> ref_div_i == $past(word_i[DIV_LSB +: DIV_W]));

  assert_short_keeps_div_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && is_short) |=> $stable(ref_div_i));
endmodule

bind ctl3w_top ctl3w_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .done_i    (frame_done),
  .len_i     (frame_len),
  .word_i    (frame_word),
  .ref_div_i (ref_div_o),
  .state_i   ({ref_div_o, pump_sel_o, buf_off_o, lvl3_o, fb_div_o, sw_off_o, dac_plain_o,
               gain_a_o, ofs_a_o, gain_b_o, ofs_b_o, tune_code_o, tune_half_pf_o})
);

// File: tb/ctl3w_top_tb_top.sv
`timescale 1ns/1ps
module ctl3w_top_tb_top;
  localparam int HALF = 52;
  localparam int NV   = 22;

  // {tag, bit count, word}
  localparam logic [40:0] VEC [NV] = '{
    {4'd3,  5'd24, 32'h00B6970C},  // R3 reference frame
    {4'd4,  5'd24, 32'h005A3CD5},  // R4 feedback frame
    {4'd5,  5'd16, 32'h0000C37C},  // R5 converter A
    {4'd5,  5'd16, 32'h00009E25},  // R5 converter B
    {4'd6,  5'd16, 32'h00008AFE},  // R6 tune, low bits ignored
    {4'd7,  5'd16, 32'h00007F02},  // R7 code 0x7F -> 127
    {4'd7,  5'd16, 32'h0000FF02},  // R7 code 0xFF -> 143
    {4'd2,  5'd24, 32'h00FFFFFC},  // R2 all ones reference
    {4'd2,  5'd24, 32'h00FFFFFD},  // R2 all ones feedback
    {4'd8,  5'd15, 32'h00007FFC},  // R8
    {4'd8,  5'd17, 32'h0001FFFC},  // R8
    {4'd8,  5'd23, 32'h007FFFFC},  // R8
    {4'd8,  5'd25, 32'h01FFFFFC},  // R8
    {4'd8,  5'd8,  32'h000000FE},  // R8
    {4'd9,  5'd16, 32'h0000FFFF},  // R9 short addr 3
    {4'd9,  5'd24, 32'h00FFFFFE},  // R9 long addr 2
    {4'd9,  5'd24, 32'h00123457},  // R9 long addr 3
    {4'd12, 5'd16, 32'h00001234},  // R12 only converter A moves
    {4'd12, 5'd24, 32'h00000000},  // R12 reference to zero
    {4'd12, 5'd24, 32'h00000001},  // R12 feedback to zero
    {4'd6,  5'd16, 32'h000055AA},  // R6 tune 0x55
    {4'd7,  5'd16, 32'h00000002}   // R7 code 0 -> 0
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, en, sclk, dat;
  logic [15:0] ref_div, fb_div;
  logic [1:0]  pump;
  logic        boff, mode;
  logic [2:0]  lvl;
  logic [3:0]  sw;
  logic [7:0]  ga, gb, tc;
  logic [5:0]  oa, ob;
  logic [8:0]  hpf;

  ctl3w_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_en_i(en), .ser_clk_i(sclk), .ser_dat_i(dat),
    .ref_div_o(ref_div), .pump_sel_o(pump), .buf_off_o(boff), .lvl3_o(lvl),
    .fb_div_o(fb_div), .sw_off_o(sw), .dac_plain_o(mode),
    .gain_a_o(ga), .ofs_a_o(oa), .gain_b_o(gb), .ofs_b_o(ob),
    .tune_code_o(tc), .tune_half_pf_o(hpf)
  );

  logic [15:0] e_ref, e_fb;
  logic [1:0]  e_pump;
  logic        e_boff, e_mode;
  logic [2:0]  e_lvl;
  logic [3:0]  e_sw;
  logic [7:0]  e_ga, e_gb, e_tc;
  logic [5:0]  e_oa, e_ob;
  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic model_reset();
    e_ref = '0; e_fb = '0; e_pump = '0; e_boff = 0; e_mode = 0; e_lvl = '0;
    e_sw = '0; e_ga = '0; e_gb = '0; e_tc = '0; e_oa = '0; e_ob = '0;
  endtask

  task automatic model(input int n, input logic [31:0] w);
    if (n == 24 && w[1:0] == 2'd0) begin
      e_ref = w[17:2]; e_lvl = w[20:18]; e_boff = w[21]; e_pump = w[23:22];
    end else if (n == 24 && w[1:0] == 2'd1) begin
      e_fb = w[17:2]; e_sw = w[21:18]; e_mode = w[22];
    end else if (n == 16) begin
      case (w[1:0])
        2'd0: begin e_ga = w[9:2]; e_oa = w[15:10]; end
        2'd1: begin e_gb = w[9:2]; e_ob = w[15:10]; end
        2'd2: e_tc = w[15:8];
        default: ;
      endcase
    end
  endtask

  task automatic check(input int tag);
    logic [87:0] act, exp;
    logic [8:0]  e_hpf;
    e_hpf = {1'b0, e_tc[7] ? 8'd16 : 8'd0} + {2'b0, e_tc[6:0]};
    act = {ref_div, pump, boff, lvl, fb_div, sw, mode, ga, oa, gb, ob, tc, hpf};
    exp = {e_ref, e_pump, e_boff, e_lvl, e_fb, e_sw, e_mode, e_ga, e_oa, e_gb, e_ob, e_tc, e_hpf};
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL R%0d actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input int n, input logic [31:0] w, input bit hold);
    @(negedge clk) en = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < n; b++) begin
      dat = w[b];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    if (!hold) begin
      en = 1'b0;
      repeat (8) @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; sclk = 1'b0; dat = 1'b0;
    model_reset();
    repeat (5) @(negedge clk);
    check(1);  // R1 during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(1);  // R1 after release

    for (int i = 0; i < NV; i++) begin
      send(int'(VEC[i][36:32]), VEC[i][31:0], 1'b0);
      model(int'(VEC[i][36:32]), VEC[i][31:0]);
      check(int'(VEC[i][40:37]));
    end

    // R10: all 24 bits in, enable still high, nothing may move yet
    send(24, 32'h003F00F0, 1'b1);
    repeat (20) @(negedge clk);
    check(10);
    en = 1'b0;
    repeat (8) @(negedge clk);
    model(24, 32'h003F00F0);
    check(10);

    // R11: clock edges with enable low must not shift bits
    dat = 1'b1;
    for (int k = 0; k < 10; k++) begin
      repeat (HALF) @(negedge clk); sclk = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b0;
    end
    send(16, 32'h00004A31, 1'b0);
    model(16, 32'h00004A31);
    check(11);

    // R1: asynchronous reset mid-run clears everything
    @(negedge clk) rst_n = 1'b0;
    #1;
    model_reset();
    check(1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule